// File: doc/BRIEF.md
# Serial Code-Memory Programming Port

This block lets an external programmer reach a 12K-byte code store over a four-wire SPI link while the chip is held in programming mode. It decodes fixed four-byte command frames and runs each write or erase as a self-timed cycle counted in system clocks. The programmer tracks progress by reading back data rather than through a busy pin.

The programming-mode input gates the whole port. While it is low, the frame logic is held clear and MISO stays low. An enable frame must be seen after each rise before the port accepts writes or erases. A fuse input can block serial writes and erases altogether. A non-zero lock field hides the stored code and refuses byte writes, but a chip erase is still accepted.

Top module: `isp_serial_prog`

## Requirements
- R1: While `prog_en` is low no command takes effect and MISO is 0. Lowering `prog_en` drops the enable state, so a write sent after it rises again, with no new enable frame, leaves memory unchanged.
- R2: A frame is 32 bits sampled on rising SCK, MSB first, in SPI mode 0: opcode byte, then address bits 15:8, then address bits 7:0, then data byte. In the fourth byte, MISO carries the read result MSB first and changes after falling SCK. During the first 24 bits MISO is 0.
- R3: Write (opcode 4Bh) and erase (opcode C3h) frames are executed only after an enable frame (opcode A5h) has been accepted since `prog_en` last rose.
- R4: A chip erase sets every byte to FFh and keeps the port busy for ERASE_CYCLES clocks. While it runs, every read returns 00h.
- R5: A write frame stores its data byte over any earlier value, with no chip erase needed first, and keeps the port busy for WRITE_CYCLES clocks.
- R6: While a write cycle runs, a read (opcode 20h) of the address being written returns the data with bit 7 inverted. Other addresses read true. Once the cycle ends, the written byte reads true.
- R7: A signature read (opcode 30h) returns 1Eh at address 0030h, 53h at address 0031h and 00h at any other address.
- R8: While `fuse_off` is high, write and erase frames are ignored.
- R9: While `lock_bits` is non-zero, reads of code return FFh and write frames are ignored. An erase is still accepted.
- R10: A write or erase frame that arrives while a write or erase cycle is running is ignored.
- R11: Code addresses run from 0000h to 2FFFh. A write above 2FFFh is ignored, and a read above 2FFFh returns FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCK must stay below one fortieth of it |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | High holds the block in serial programming mode |
| fuse_off | input | 1 | High disables serial write and erase |
| lock_bits | input | 2 | Non-zero hides code and blocks byte writes |
| sck | input | 1 | SPI serial clock from the programmer |
| mosi | input | 1 | SPI data from the programmer |
| miso | output | 1 | SPI data to the programmer |

## Verification
SCK and MOSI pass through a two-stage synchroniser. A rising SCK edge therefore reaches the frame logic about three clocks after the pin changes, and MISO moves about three clocks after each falling SCK. The bench samples MISO just before it raises SCK, twenty clocks after the preceding fall. The read byte is chosen when the 24th bit arrives, and a frame's command takes effect about three clocks after its 32nd rising edge; the busy window of WRITE_CYCLES or ERASE_CYCLES clocks opens there. The bench model stamps both moments with its own cycle counter. Every polled read is placed several hundred clocks away from the end of a busy window.

// File: rtl/isp_pkg.sv
package isp_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_WRITE = 2'd1,
        CYC_ERASE = 2'd2
    } cyc_mode_e;

    localparam logic [7:0] OP_ENABLE = 8'hA5;
    localparam logic [7:0] OP_ERASE  = 8'hC3;
    localparam logic [7:0] OP_WRITE  = 8'h4B;
    localparam logic [7:0] OP_READ   = 8'h20;
    localparam logic [7:0] OP_SIG    = 8'h30;

    localparam logic [15:0] SIG_ADDR_LO = 16'h0030;
    localparam logic [15:0] SIG_ADDR_HI = 16'h0031;
    localparam logic [7:0]  SIG_BYTE_LO = 8'h1E;
    localparam logic [7:0]  SIG_BYTE_HI = 8'h53;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic mosi_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0]   sck;
        logic [SYNC_STAGES-1:0] mosi;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sck  = {st_q.sck[SYNC_STAGES-1:0], sck_i};
        st_d.mosi = {st_q.mosi[SYNC_STAGES-2:0], mosi_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sck[SYNC_STAGES-1] & ~st_q.sck[SYNC_STAGES];
    assign fall_o = ~st_q.sck[SYNC_STAGES-1] & st_q.sck[SYNC_STAGES];
    assign mosi_o = st_q.mosi[SYNC_STAGES-1];
endmodule

// File: rtl/isp_frame.sv
module isp_frame #(
    parameter int BYTE_W      = 8,
    parameter int FRAME_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic                mosi_i,
    input  logic [BYTE_W-1:0]   rd_byte_i,
    output logic                hdr_valid_o,
    output logic [BYTE_W-1:0]   hdr_op_o,
    output logic [2*BYTE_W-1:0] hdr_addr_o,
    output logic                frm_valid_o,
    output logic [BYTE_W-1:0]   frm_op_o,
    output logic [2*BYTE_W-1:0] frm_addr_o,
    output logic [BYTE_W-1:0]   frm_data_o,
    output logic                miso_o
);
    localparam int FRAME_BITS = BYTE_W * FRAME_BYTES;
    localparam int HDR_BITS   = FRAME_BITS - BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [CNT_W-1:0]      bitcnt;
        logic [FRAME_BITS-2:0] shreg;
        logic [BYTE_W-1:0]     tx;
        logic                  miso;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [FRAME_BITS-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.shreg, mosi_i};

        hdr_valid_o = active_i & rise_i & (st_q.bitcnt == CNT_W'(HDR_BITS - 1));
        frm_valid_o = active_i & rise_i & (st_q.bitcnt == CNT_W'(FRAME_BITS - 1));
        hdr_op_o    = shifted[HDR_BITS-1 -: BYTE_W];
        hdr_addr_o  = shifted[2*BYTE_W-1:0];
        frm_op_o    = shifted[FRAME_BITS-1 -: BYTE_W];
        frm_addr_o  = shifted[FRAME_BITS-BYTE_W-1 -: 2*BYTE_W];
        frm_data_o  = shifted[BYTE_W-1:0];

        if (!active_i) begin
            st_d = '0;
        end else begin
            if (rise_i) begin
                st_d.shreg = shifted[FRAME_BITS-2:0];
                if (st_q.bitcnt == CNT_W'(FRAME_BITS - 1)) st_d.bitcnt = '0;
                else                                      st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.bitcnt == CNT_W'(HDR_BITS - 1))  st_d.tx = rd_byte_i;
            end
            if (fall_i) begin
                if (st_q.bitcnt >= CNT_W'(HDR_BITS)) begin
                    st_d.miso = st_q.tx[BYTE_W-1];
                    st_d.tx   = {st_q.tx[BYTE_W-2:0], 1'b0};
                end else begin
                    st_d.miso = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_o = st_q.miso;

    // MISO stays low through the command and address bytes
    assert_miso_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bitcnt >= CNT_W'(1) && st_q.bitcnt < CNT_W'(HDR_BITS)) |-> !st_q.miso);
endmodule

// File: rtl/isp_core.sv
module isp_core
    import isp_pkg::*;
#(
    parameter int MEM_BYTES    = 12288,
    parameter int WRITE_CYCLES = 3000,
    parameter int ERASE_CYCLES = 8000,
    parameter int ADDR_W       = 16,
    parameter int LOCK_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              fuse_off_i,
    input  logic [LOCK_W-1:0] lock_i,
    input  logic              hdr_valid_i,
    input  logic [7:0]        hdr_op_i,
    input  logic [ADDR_W-1:0] hdr_addr_i,
    input  logic              frm_valid_i,
    input  logic [7:0]        frm_op_i,
    input  logic [ADDR_W-1:0] frm_addr_i,
    input  logic [7:0]        frm_data_i,
    output logic [7:0]        rd_byte_o
);
    localparam int LANES   = 4;
    localparam int WORD_W  = 8 * LANES;
    localparam int WORDS   = MEM_BYTES / LANES;
    localparam int WIDX_W  = $clog2(WORDS);
    localparam int TMR_MAX = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        logic              en;
        cyc_mode_e         mode;
        logic [TMR_W-1:0]  timer;
        logic [ADDR_W-1:0] last_addr;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [WORD_W-1:0] mem_q [WORDS];
    logic              mem_we;
    logic [WIDX_W-1:0] mem_widx;
    logic [WORD_W-1:0] mem_wword;

    logic              wr_ok;
    logic [WIDX_W-1:0] wr_idx;
    logic              rd_in_range;
    logic [WIDX_W-1:0] rd_idx;
    logic [WORD_W-1:0] rd_word;
    logic [7:0]        rd_cell;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_widx  = '0;
        mem_wword = '0;
        wr_idx    = frm_addr_i[WIDX_W+1:2];
        wr_ok     = st_q.en && !fuse_off_i && (st_q.mode == CYC_IDLE);

        case (st_q.mode)
            CYC_WRITE: begin
                if (st_q.timer == TMR_W'(WRITE_CYCLES - 1)) begin
                    st_d.mode  = CYC_IDLE;
                    st_d.timer = '0;
                end else begin
                    st_d.timer = st_q.timer + 1'b1;
                end
            end
            CYC_ERASE: begin
                if (st_q.timer < TMR_W'(WORDS)) begin
                    mem_we    = 1'b1;
                    mem_widx  = st_q.timer[WIDX_W-1:0];
                    mem_wword = '1;
                end
                if (st_q.timer == TMR_W'(ERASE_CYCLES - 1)) begin
                    st_d.mode  = CYC_IDLE;
                    st_d.timer = '0;
                end else begin
                    st_d.timer = st_q.timer + 1'b1;
                end
            end
            default: ;
        endcase

        if (!active_i) begin
            st_d.en = 1'b0;
        end else if (frm_valid_i) begin
            case (frm_op_i)
                OP_ENABLE: st_d.en = 1'b1;
                OP_ERASE: begin
                    if (wr_ok) begin
                        st_d.mode  = CYC_ERASE;
                        st_d.timer = '0;
                    end
                end
                OP_WRITE: begin
                    if (wr_ok && (lock_i == '0) && (frm_addr_i < ADDR_W'(MEM_BYTES))) begin
                        st_d.mode      = CYC_WRITE;
                        st_d.timer     = '0;
                        st_d.last_addr = frm_addr_i;
                        mem_we         = 1'b1;
                        mem_widx       = wr_idx;
                        mem_wword      = mem_q[wr_idx];
                        mem_wword[{frm_addr_i[1:0], 3'b000} +: 8] = frm_data_i;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_in_range = hdr_addr_i < ADDR_W'(MEM_BYTES);
        rd_idx      = rd_in_range ? hdr_addr_i[WIDX_W+1:2] : '0;
        rd_word     = mem_q[rd_idx];
        rd_cell     = rd_word[{hdr_addr_i[1:0], 3'b000} +: 8];
        rd_byte_o   = 8'h00;
        if (hdr_op_i == OP_SIG) begin
            if (hdr_addr_i == SIG_ADDR_LO)      rd_byte_o = SIG_BYTE_LO;
            else if (hdr_addr_i == SIG_ADDR_HI) rd_byte_o = SIG_BYTE_HI;
        end else if (hdr_op_i == OP_READ) begin
            if (st_q.mode == CYC_ERASE)            rd_byte_o = 8'h00;
            else if (lock_i != '0 || !rd_in_range) rd_byte_o = 8'hFF;
            else if (st_q.mode == CYC_WRITE && hdr_addr_i == st_q.last_addr)
                rd_byte_o = rd_cell ^ 8'h80;
            else
                rd_byte_o = rd_cell;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, mode: CYC_IDLE, timer: '0, last_addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[mem_widx] <= mem_wword;
    end

    assert_enable_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !st_q.en);

    assert_start_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != CYC_IDLE && $past(st_q.mode) == CYC_IDLE) |-> $past(st_q.en));

    assert_erase_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CYC_ERASE && hdr_valid_i && hdr_op_i == OP_READ) |-> rd_byte_o == 8'h00);

    assert_fuse_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CYC_IDLE && fuse_off_i) |=> st_q.mode == CYC_IDLE);

    assert_lock_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CYC_IDLE && lock_i != '0) |=> st_q.mode != CYC_WRITE);

    assert_busy_holds_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != CYC_IDLE) |=> $stable(st_q.last_addr));
endmodule

// File: rtl/isp_serial_prog.sv
module isp_serial_prog #(
    parameter int MEM_BYTES    = 12288,
    parameter int WRITE_CYCLES = 3000,
    parameter int ERASE_CYCLES = 8000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en,
    input  logic       fuse_off,
    input  logic [1:0] lock_bits,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso
);
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    logic              rise, fall, mosi_s;
    logic              hdr_valid, frm_valid;
    logic [BYTE_W-1:0] hdr_op, frm_op, frm_data, rd_byte;
    logic [ADDR_W-1:0] hdr_addr, frm_addr;

    isp_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi),
        .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s)
    );

    isp_frame #(.BYTE_W(BYTE_W), .FRAME_BYTES(4)) frame_i (
        .clk(clk), .rst_n(rst_n), .active_i(prog_en),
        .rise_i(rise), .fall_i(fall), .mosi_i(mosi_s), .rd_byte_i(rd_byte),
        .hdr_valid_o(hdr_valid), .hdr_op_o(hdr_op), .hdr_addr_o(hdr_addr),
        .frm_valid_o(frm_valid), .frm_op_o(frm_op), .frm_addr_o(frm_addr),
        .frm_data_o(frm_data), .miso_o(miso)
    );

    isp_core #(
        .MEM_BYTES(MEM_BYTES), .WRITE_CYCLES(WRITE_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .ADDR_W(ADDR_W), .LOCK_W(2)
    ) core_i (
        .clk(clk), .rst_n(rst_n), .active_i(prog_en),
        .fuse_off_i(fuse_off), .lock_i(lock_bits),
        .hdr_valid_i(hdr_valid), .hdr_op_i(hdr_op), .hdr_addr_i(hdr_addr),
        .frm_valid_i(frm_valid), .frm_op_i(frm_op), .frm_addr_i(frm_addr),
        .frm_data_i(frm_data), .rd_byte_o(rd_byte)
    );
endmodule

// File: tb/isp_serial_prog_tb_top.sv
module isp_serial_prog_tb_top;
    localparam int WRITE_C = 3000;
    localparam int ERASE_C = 8000;
    localparam int MEMSZ   = 12288;
    localparam int HP      = 20;
    localparam int GAP     = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0;
    logic       fuse_off = 1'b0;
    logic [1:0] lock_bits = 2'b00;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // behavioural reference model
    bit       m_en = 1'b0;
    int       busy_end = 0;
    int       busy_kind = 0;
    int       last_a = 0;
    bit [7:0] m_mem [int];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    isp_serial_prog #(.MEM_BYTES(MEMSZ), .WRITE_CYCLES(WRITE_C),
                      .ERASE_CYCLES(ERASE_C), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .fuse_off(fuse_off),
        .lock_bits(lock_bits), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic bit [7:0] exp_read(input bit [7:0] op, input int a, input int h);
        bit busy = (h < busy_end);
        bit [7:0] v;
        if (op == 8'h30) return (a == 'h30) ? 8'h1E : (a == 'h31) ? 8'h53 : 8'h00;
        if (op != 8'h20) return 8'h00;
        if (busy && busy_kind == 2) return 8'h00;
        if (lock_bits != 0 || a >= MEMSZ) return 8'hFF;
        v = m_mem.exists(a) ? m_mem[a] : 8'hFF;
        if (busy && busy_kind == 1 && a == last_a) v = v ^ 8'h80;
        return v;
    endfunction

    function automatic void apply(input bit [7:0] op, input int a, input bit [7:0] d, input int e);
        bit busy = (e < busy_end);
        if (op == 8'hA5) m_en = 1'b1;
        else if (op == 8'hC3 && m_en && !fuse_off && !busy) begin
            m_mem.delete();
            busy_kind = 2; busy_end = e + ERASE_C;
        end else if (op == 8'h4B && m_en && !fuse_off && lock_bits == 0 && !busy && a < MEMSZ) begin
            m_mem[a] = d; last_a = a;
            busy_kind = 1; busy_end = e + WRITE_C;
        end
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input bit [7:0] op, input int a, input bit [7:0] d,
                         input bit chk, input string req);
        logic [31:0] w = {op, a[15:0], d};
        logic [7:0]  rd = '0;
        bit [7:0]    exp = '0;
        bit          nz = 1'b0;
        int          ecyc = 0;
        for (int i = 0; i < 32; i++) begin
            mosi = w[31-i];
            idle(HP);
            if (i >= 24) rd[31-i] = miso;
            else if (miso !== 1'b0) nz = 1'b1;
            sck = 1'b1;
            if (i == 23) exp = exp_read(op, a, cyc);
            if (i == 31) ecyc = cyc;
            idle(HP);
            sck = 1'b0;
        end
        apply(op, a, d, ecyc);
        idle(GAP);
        check("R2 miso low in header", {7'd0, nz}, 8'h00);
        if (chk) check(req, rd, exp);
    endtask

    initial begin
        idle(4);
        check("R1 reset miso", {7'd0, miso}, 8'h00);
        rst_n = 1'b1;
        idle(4);
        prog_en = 1'b1;
        idle(4);
        // R4: erase then poll during and after
        frame(8'hA5, 0, 0, 0, "");
        frame(8'hC3, 0, 0, 0, "");
        frame(8'h20, 'h0100, 0, 1, "R4 read during erase");
        idle(ERASE_C);
        frame(8'h20, 'h0100, 0, 1, "R4 read after erase");
        // R1 and R3: drop programming mode, enable must be repeated
        prog_en = 1'b0; m_en = 1'b0;
        idle(4);
        check("R1 miso low when inactive", {7'd0, miso}, 8'h00);
        prog_en = 1'b1;
        idle(4);
        frame(8'h4B, 'h0500, 8'h66, 0, "");
        idle(WRITE_C);
        frame(8'h20, 'h0500, 0, 1, "R3 write without enable ignored");
        frame(8'hA5, 0, 0, 0, "");
        // R5 and R6: write, poll, overwrite
        frame(8'h4B, 'h0100, 8'h5A, 0, "");
        frame(8'h20, 'h0100, 0, 1, "R6 polled read inverted msb");
        frame(8'h20, 'h0101, 0, 1, "R6 other address true");
        idle(WRITE_C);
        frame(8'h20, 'h0100, 0, 1, "R5 written byte");
        frame(8'h4B, 'h0100, 8'hA5, 0, "");
        idle(WRITE_C);
        frame(8'h20, 'h0100, 0, 1, "R5 overwrite without erase");
        // R10: second write during busy
        frame(8'h4B, 'h0200, 8'h11, 0, "");
        frame(8'h4B, 'h0201, 8'h22, 0, "");
        idle(WRITE_C);
        frame(8'h20, 'h0201, 0, 1, "R10 busy write ignored");
        frame(8'h20, 'h0200, 0, 1, "R10 first write kept");
        // R7 signature
        frame(8'h30, 'h0030, 0, 1, "R7 signature low");
        frame(8'h30, 'h0031, 0, 1, "R7 signature high");
        frame(8'h30, 'h0032, 0, 1, "R7 signature other");
        // R11 address range
        frame(8'h4B, 'h2FFF, 8'h77, 0, "");
        idle(WRITE_C);
        frame(8'h20, 'h2FFF, 0, 1, "R11 top address");
        frame(8'h4B, 'h3000, 8'h33, 0, "");
        frame(8'h20, 'h3000, 0, 1, "R11 above range");
        // R8 fuse
        fuse_off = 1'b1;
        frame(8'h4B, 'h0300, 8'h44, 0, "");
        idle(WRITE_C);
        frame(8'h20, 'h0300, 0, 1, "R8 write ignored");
        frame(8'hC3, 0, 0, 0, "");
        frame(8'h20, 'h0100, 0, 1, "R8 erase ignored");
        fuse_off = 1'b0;
        // R9 lock
        lock_bits = 2'b01;
        frame(8'h20, 'h0100, 0, 1, "R9 locked read");
        frame(8'h4B, 'h0400, 8'h12, 0, "");
        idle(WRITE_C);
        frame(8'hC3, 0, 0, 0, "");
        frame(8'h20, 'h0100, 0, 1, "R9 erase accepted while locked");
        idle(ERASE_C);
        lock_bits = 2'b00;
        frame(8'h20, 'h0400, 0, 1, "R9 locked write ignored");
        frame(8'h20, 'h0100, 0, 1, "R9 erased after lock");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule